// File: doc/BRIEF.md
# Register File with Remappable Low Bank

This block is a 32-entry, 32-bit general-purpose register file with two combinational read ports and one clocked write port. It also holds a four-entry alternate bank that can stand in for the four lowest registers. A single mode bit inside a 32-bit machine-state word selects the mapping. When the bit is clear, every index reaches the ordinary registers. When it is set, indices 0 to 3 reach the alternate entries, and the ordinary registers 0 to 3 stay frozen.

Translation-miss handlers use the alternate bank as scratch space without saving any live registers. Taking an instruction-fetch, data-load or data-store translation miss sets the mode bit. The return-from-exception strobe clears it. Software can also load the whole state word through a move-to-state-register port.

While the alternate bank is active, any index from 4 to 31 is treated as an illegal access. The block raises a flag for it, returns zero on a read and drops a write.

Top module: `swap_regfile`

## Requirements
- R1: With the mode bit clear, a write to any index 0–31 updates that ordinary register at the clock edge, and later reads of that index return the written value on both read ports.
- R2: With the mode bit set, reads and writes of indices 0–3 reach alternate entries 0–3. The ordinary registers 0–3 keep their contents, and those contents are visible again once the bit clears. Alternate-bank contents persist across mode changes.
- R3: With the mode bit set, a read of index 4–31 raises that port's illegal flag and returns zero. A write of such an index raises the write illegal flag and changes no register.
- R4: An instruction-fetch, data-load or data-store translation-miss strobe sets the mode bit at the next clock edge.
- R5: The return-from-exception strobe clears the mode bit at the next clock edge.
- R6: Priority is: any miss strobe, then the return strobe, then a state-word write. A miss together with a return leaves the bit set. A return together with a state-word write loads the word but clears the bit.
- R7: A state-word write loads all 32 bits, which read back on the state output. The mode bit is bit 14 counting from the most significant bit as 0, so it is value bit 17 (mask 0x00020000).
- R8: Accesses in a cycle use the mode bit registered at the start of that cycle, so a mode change affects accesses from the next cycle on.
- R9: A read in the same cycle as an effective write to the same physical entry, ordinary or alternate, returns the new write data.
- R10: Reset clears the mode bit, the state word, all ordinary registers and all alternate entries to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | 5 | Read port A register index |
| rdDataA | output | 32 | Read port A data |
| rdIllegalA | output | 1 | Read port A index not reachable in the current mode |
| rdAddrB | input | 5 | Read port B register index |
| rdDataB | output | 32 | Read port B data |
| rdIllegalB | output | 1 | Read port B index not reachable in the current mode |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write register index |
| wrData | input | 32 | Write data |
| wrIllegal | output | 1 | Write requested to an unreachable index; write dropped |
| instMiss | input | 1 | Instruction-fetch translation miss taken |
| loadMiss | input | 1 | Data-load translation miss taken |
| storeMiss | input | 1 | Data-store translation miss taken |
| excReturn | input | 1 | Return-from-exception executed |
| stateWrEn | input | 1 | Move-to-state-word write enable |
| stateWrData | input | 32 | Move-to-state-word data |
| stateRdData | output | 32 | Current state word |
| remapMode | output | 1 | Current mode bit |

## Verification
The most likely internal faults are a mode bit of the wrong value and a write that lands in the wrong bank. A wrong mode bit shows at the ports in the same cycle through the mode and state outputs. It also shows through the illegal flags on any read of index 4 or above. A write that lands in the wrong bank stays hidden until the mode flips back. For that reason the vectors write in one mode, switch, and then read the same indices, so that corrupted ordinary or alternate contents show up within a few cycles.

// File: rtl/swap_rf_pkg.sv
package swap_rf_pkg;
  // Strobes from the control part to the storage part.
  typedef struct packed {
    logic remap;      // alternate low bank selected
  } ctrlStrobes_t;
endpackage

// File: rtl/swap_rf_ctrl.sv
module swap_rf_ctrl
  import swap_rf_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int MODE_POS = 14   // bit 0 = most significant bit
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instMiss,
  input  logic            loadMiss,
  input  logic            storeMiss,
  input  logic            excReturn,
  input  logic            stateWrEn,
  input  logic [XLEN-1:0] stateWrData,
  output logic [XLEN-1:0] stateQ,
  output ctrlStrobes_t    ctrlOut
);
  localparam int MODE_IDX = XLEN - 1 - MODE_POS;

  logic            missAny;
  logic [XLEN-1:0] stateD;

  assign missAny = instMiss | loadMiss | storeMiss;

  // Lowest priority first, highest last.
  always_comb begin
    stateD = stateQ;
    if (stateWrEn) stateD = stateWrData;
    if (excReturn) stateD[MODE_IDX] = 1'b0;
    if (missAny)   stateD[MODE_IDX] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= '0;
    else       stateQ <= stateD;
  end

  assign ctrlOut.remap = stateQ[MODE_IDX];

  p_miss_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    missAny |=> ctrlOut.remap);
  p_return_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (excReturn && !missAny) |=> !ctrlOut.remap);
  p_entry_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (missAny && excReturn && stateWrEn && !stateWrData[MODE_IDX]) |=> ctrlOut.remap);
  p_word_loads_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateWrEn && !missAny && !excReturn) |=> stateQ == $past(stateWrData));
  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stateWrEn && !missAny && !excReturn) |=> $stable(stateQ));
endmodule

// File: rtl/swap_rf_dp.sv
module swap_rf_dp
  import swap_rf_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NREG    = 32,
  parameter int NSHADOW = 4,
  parameter int NRD     = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobes_t                      ctrlIn,
  input  logic [NRD-1:0][$clog2(NREG)-1:0]  rdAddr,
  output logic [NRD-1:0][XLEN-1:0]          rdData,
  output logic [NRD-1:0]                    rdIllegal,
  input  logic                              wrEn,
  input  logic [$clog2(NREG)-1:0]           wrAddr,
  input  logic [XLEN-1:0]                   wrData,
  output logic                              wrIllegal
);
  localparam int AW = $clog2(NREG);
  localparam int SW = $clog2(NSHADOW);
  localparam logic [AW-1:0] LOW_LIMIT = AW'(NSHADOW);

  logic [XLEN-1:0] normMem [NREG];
  logic [XLEN-1:0] shadMem [NSHADOW];

  logic wrLow, wrNorm, wrShad, wrLive;

  assign wrLow     = wrAddr < LOW_LIMIT;
  assign wrIllegal = wrEn && ctrlIn.remap && !wrLow;
  assign wrNorm    = wrEn && !ctrlIn.remap;
  assign wrShad    = wrEn && ctrlIn.remap && wrLow;
  assign wrLive    = wrNorm || wrShad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++)    normMem[i] <= '0;
      for (int j = 0; j < NSHADOW; j++) shadMem[j] <= '0;
    end else begin
      if (wrNorm) normMem[wrAddr] <= wrData;
      if (wrShad) shadMem[wrAddr[SW-1:0]] <= wrData;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic rdLow;
    assign rdLow = rdAddr[p] < LOW_LIMIT;
    always_comb begin
      rdIllegal[p] = ctrlIn.remap && !rdLow;
      if (rdIllegal[p])                     rdData[p] = '0;
      else if (wrLive && wrAddr == rdAddr[p]) rdData[p] = wrData;
      else if (ctrlIn.remap)                rdData[p] = shadMem[rdAddr[p][SW-1:0]];
      else                                  rdData[p] = normMem[rdAddr[p]];
    end
    p_illegal_reads_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
      rdIllegal[p] |-> rdData[p] == '0);
  end

  for (genvar i = 0; i < NSHADOW; i++) begin : g_guard
    p_normal_frozen_r2: assert property (@(posedge clk) disable iff (!rstN)
      ctrlIn.remap |=> $stable(normMem[i]));
    p_shadow_frozen_r1: assert property (@(posedge clk) disable iff (!rstN)
      !ctrlIn.remap |=> $stable(shadMem[i]));
  end

  p_dropped_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrIllegal |-> !wrLive);
endmodule

// File: rtl/swap_regfile.sv
module swap_regfile
  import swap_rf_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NREG     = 32,
  parameter int NSHADOW  = 4,
  parameter int MODE_POS = 14
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [$clog2(NREG)-1:0] rdAddrA,
  output logic [XLEN-1:0]         rdDataA,
  output logic                    rdIllegalA,
  input  logic [$clog2(NREG)-1:0] rdAddrB,
  output logic [XLEN-1:0]         rdDataB,
  output logic                    rdIllegalB,
  input  logic                    wrEn,
  input  logic [$clog2(NREG)-1:0] wrAddr,
  input  logic [XLEN-1:0]         wrData,
  output logic                    wrIllegal,
  input  logic                    instMiss,
  input  logic                    loadMiss,
  input  logic                    storeMiss,
  input  logic                    excReturn,
  input  logic                    stateWrEn,
  input  logic [XLEN-1:0]         stateWrData,
  output logic [XLEN-1:0]         stateRdData,
  output logic                    remapMode
);
  localparam int AW = $clog2(NREG);

  ctrlStrobes_t             ctrlBus;
  logic [1:0][AW-1:0]       rdAddrVec;
  logic [1:0][XLEN-1:0]     rdDataVec;
  logic [1:0]               rdIllVec;

  assign rdAddrVec  = {rdAddrB, rdAddrA};
  assign rdDataA    = rdDataVec[0];
  assign rdDataB    = rdDataVec[1];
  assign rdIllegalA = rdIllVec[0];
  assign rdIllegalB = rdIllVec[1];
  assign remapMode  = ctrlBus.remap;

  swap_rf_ctrl #(.XLEN(XLEN), .MODE_POS(MODE_POS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .instMiss(instMiss), .loadMiss(loadMiss), .storeMiss(storeMiss),
    .excReturn(excReturn), .stateWrEn(stateWrEn), .stateWrData(stateWrData),
    .stateQ(stateRdData), .ctrlOut(ctrlBus)
  );

  swap_rf_dp #(.XLEN(XLEN), .NREG(NREG), .NSHADOW(NSHADOW), .NRD(2)) dp_i (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlBus),
    .rdAddr(rdAddrVec), .rdData(rdDataVec), .rdIllegal(rdIllVec),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrIllegal(wrIllegal)
  );

  p_reset_clear_r10: assert property (@(posedge clk)
    $rose(rstN) |-> (stateRdData == '0));
endmodule

// File: tb/swap_regfile_tb_top.sv
`timescale 1ns/1ps
module swap_regfile_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0]  rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData, stateWrData, stateRdData;
  logic rdIllegalA, rdIllegalB, wrEn, wrIllegal;
  logic instMiss, loadMiss, storeMiss, excReturn, stateWrEn, remapMode;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  swap_regfile dut_i (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdIllegalA(rdIllegalA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .rdIllegalB(rdIllegalB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrIllegal(wrIllegal),
    .instMiss(instMiss), .loadMiss(loadMiss), .storeMiss(storeMiss),
    .excReturn(excReturn), .stateWrEn(stateWrEn), .stateWrData(stateWrData),
    .stateRdData(stateRdData), .remapMode(remapMode)
  );

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_MI = 3'd2, OP_ML = 3'd3,
                         OP_MS = 3'd4, OP_RET = 3'd5, OP_SW = 3'd6;
  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  req;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        ill;
  } vec_t;

  localparam int NV = 22;
  localparam logic [76:0] VECS [NV] = '{
    {OP_WR, 4'd1, 5'd1,  32'h11111111, 32'h0,        1'b0},
    {OP_WR, 4'd1, 5'd5,  32'h55555555, 32'h0,        1'b0},
    {OP_RD, 4'd1, 5'd1,  32'h0,        32'h11111111, 1'b0},
    {OP_MI, 4'd4, 5'd0,  32'h0,        32'h0,        1'b0},
    {OP_RD, 4'd2, 5'd1,  32'h0,        32'h0,        1'b0},
    {OP_WR, 4'd2, 5'd1,  32'hAAAA0001, 32'h0,        1'b0},
    {OP_RD, 4'd2, 5'd1,  32'h0,        32'hAAAA0001, 1'b0},
    {OP_WR, 4'd3, 5'd5,  32'hDEAD0005, 32'h0,        1'b1},
    {OP_RD, 4'd3, 5'd5,  32'h0,        32'h0,        1'b1},
    {OP_RET,4'd5, 5'd0,  32'h0,        32'h0,        1'b0},
    {OP_RD, 4'd2, 5'd1,  32'h0,        32'h11111111, 1'b0},
    {OP_RD, 4'd3, 5'd5,  32'h0,        32'h55555555, 1'b0},
    {OP_ML, 4'd4, 5'd0,  32'h0,        32'h0,        1'b0},
    {OP_RD, 4'd2, 5'd1,  32'h0,        32'hAAAA0001, 1'b0},
    {OP_RET,4'd5, 5'd0,  32'h0,        32'h0,        1'b0},
    {OP_MS, 4'd4, 5'd0,  32'h0,        32'h0,        1'b0},
    {OP_RD, 4'd4, 5'd31, 32'h0,        32'h0,        1'b1},
    {OP_RET,4'd5, 5'd0,  32'h0,        32'h0,        1'b0},
    {OP_SW, 4'd7, 5'd0,  32'h00020000, 32'h0,        1'b0},
    {OP_RD, 4'd7, 5'd1,  32'h0,        32'hAAAA0001, 1'b0},
    {OP_SW, 4'd7, 5'd0,  32'h00000000, 32'h0,        1'b0},
    {OP_RD, 4'd7, 5'd1,  32'h0,        32'h11111111, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    rdAddrA = '0; rdAddrB = '0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    instMiss = 1'b0; loadMiss = 1'b0; storeMiss = 1'b0; excReturn = 1'b0;
    stateWrEn = 1'b0; stateWrData = '0;
  endtask

  task automatic finishCycle();
    @(posedge clk); #1;
    idleInputs();
  endtask

  task automatic runVec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    case (v.op)
      OP_WR: begin wrEn = 1'b1; wrAddr = v.addr; wrData = v.data; end
      OP_RD: begin rdAddrA = v.addr; rdAddrB = v.addr; end
      OP_MI: instMiss = 1'b1;
      OP_ML: loadMiss = 1'b1;
      OP_MS: storeMiss = 1'b1;
      OP_RET: excReturn = 1'b1;
      default: begin stateWrEn = 1'b1; stateWrData = v.data; end
    endcase
    #1;
    if (v.op == OP_RD) begin
      check(tag, rdDataA, v.exp);
      check(tag, rdDataB, v.exp);
      check(tag, {31'd0, rdIllegalA}, {31'd0, v.ill});
    end
    if (v.op == OP_WR) check(tag, {31'd0, wrIllegal}, {31'd0, v.ill});
    finishCycle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic allZero;
    idleInputs();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    allZero = 1'b1;
    for (int i = 0; i < 32; i++) begin
      rdAddrA = 5'(i); #1;
      if (rdDataA !== 32'h0) allZero = 1'b0;
    end
    check("R10", {31'd0, allZero}, 32'd1);
    check("R10", stateRdData, 32'h0);
    check("R10", {31'd0, remapMode}, 32'd0);
    idleInputs();

    for (int i = 0; i < NV; i++) runVec(vec_t'(VECS[i]));

    // R8: miss strobe does not affect the same cycle's read
    @(negedge clk);
    instMiss = 1'b1; rdAddrA = 5'd1; #1;
    check("R8", rdDataA, 32'h11111111);
    check("R8", {31'd0, remapMode}, 32'd0);
    finishCycle();
    check("R8", {31'd0, remapMode}, 32'd1);
    check("R7", stateRdData, 32'h00020000);

    // R9: bypass in alternate mode, and a dropped write gives no bypass
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd2; wrData = 32'h000000B2;
    rdAddrA = 5'd2; rdAddrB = 5'd9; #1;
    check("R9", rdDataA, 32'h000000B2);
    check("R3", {31'd0, rdIllegalB}, 32'd1);
    finishCycle();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd9; wrData = 32'h00000999; rdAddrA = 5'd9; #1;
    check("R3", rdDataA, 32'h0);
    finishCycle();

    // R6: miss and return in the same cycle
    @(negedge clk); excReturn = 1'b1; finishCycle();
    @(negedge clk); instMiss = 1'b1; excReturn = 1'b1; finishCycle();
    check("R6", {31'd0, remapMode}, 32'd1);
    @(negedge clk); storeMiss = 1'b1; stateWrEn = 1'b1; stateWrData = 32'h0; finishCycle();
    check("R6", stateRdData, 32'h00020000);
    @(negedge clk); excReturn = 1'b1; stateWrEn = 1'b1; stateWrData = 32'h00020000; finishCycle();
    check("R6", stateRdData, 32'h0);

    // R7: full word load and mode bit position
    @(negedge clk); stateWrEn = 1'b1; stateWrData = 32'hFFFFFFFF; finishCycle();
    check("R7", stateRdData, 32'hFFFFFFFF);
    check("R7", {31'd0, remapMode}, 32'd1);
    @(negedge clk); stateWrEn = 1'b1; stateWrData = 32'hFFFDFFFF; finishCycle();
    check("R7", {31'd0, remapMode}, 32'd0);

    // R9: bypass in ordinary mode on both ports; r9 must not hold the dropped write
    @(negedge clk); rdAddrA = 5'd9; #1;
    check("R3", rdDataA, 32'h0);
    wrEn = 1'b1; wrAddr = 5'd9; wrData = 32'h00000009; rdAddrB = 5'd9; #1;
    check("R9", rdDataA, 32'h00000009);
    check("R9", rdDataB, 32'h00000009);
    finishCycle();
    @(negedge clk); rdAddrA = 5'd9; #1;
    check("R1", rdDataA, 32'h00000009);
    idleInputs();

    // R10: reset in mid-run
    @(negedge clk); rstN = 1'b0; #1; rstN = 1'b1;
    rdAddrA = 5'd1; #1;
    check("R10", rdDataA, 32'h0);
    check("R10", stateRdData, 32'h0);
    idleInputs();

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule